// File: doc/BRIEF.md
# DMA Stream Configuration Lookup

This unit turns a DMA request's identity into the translation context that later stages need. A request arrives with a stream ID, which names the issuing device, for example a PCIe bus/device/function number. It may also carry a substream ID, which names a process address space on that device. The unit reads the stream's entry and takes the stage-2 table base and VMID from it. When the entry enables stage 1, the unit also reads a context descriptor chosen by the substream ID. That descriptor gives the stage-1 table base and ASID.

The stream table can be addressed in two ways. In the linear layout, the stream ID indexes the table directly. In the two-level layout, the upper stream ID bits select a level-1 descriptor. That descriptor points into a shared pool of entries, and the lower bits select the entry. Several entries may name the same context descriptor range and the same stage-2 base.

A host port loads all tables. A lookup that fails produces a fault event carrying the stream ID and a cause code. In that case no configuration is output.

Top module: `dma_stream_cfg_lookup`

## Requirements
- R1: While reset is held and after its release, `req_ready` is 1 and `cfg_valid` and `evt_valid` are 0.
- R2: Only one lookup is in flight at a time. `req_ready` is 0 from the cycle after acceptance until the result cycle. The result is a single-cycle pulse on either `cfg_valid` or `evt_valid`. The pulse appears N clock edges after the accepting edge, where N is the number of table reads made: 1 for the level-1 descriptor when used, 1 for the stream entry, and 1 for the context descriptor when it is read.
- R3: In the linear layout (`mode_two_level`=0), the stream entry is `stream_entry[sid]`. If the entry is valid with stage 1 off, the output carries its stage-2 base and VMID, with `cfg_s1_en`=0.
- R4: For an entry with stage 1 on, the context descriptor index is (entry cd_base + substream ID) mod 32. A request with no substream ID uses substream 0. The output carries the descriptor's stage-1 base and ASID and the entry's stage-2 base and VMID.
- R5: In the two-level layout, the level-1 index is sid >> `l2_bits`. The entry index is (descriptor pointer + (sid mod 2^`l2_bits`)) mod 64.
- R6: `mode_two_level` and `l2_bits` are sampled only at acceptance. Changing them during a lookup does not alter its result or timing.
- R7: An invalid stream entry raises an event with cause 1.
- R8: An invalid level-1 descriptor raises an event with cause 2.
- R9: A request that carries a substream ID to an entry with stage 1 off is dropped with an event of cause 3.
- R10: When stage 1 is on, a substream ID with (ssid >> cd_log2) != 0 raises an event with cause 4.
- R11: An invalid context descriptor raises an event with cause 5.
- R12: Each result carries the request's stream ID. A configuration with stage 1 off has a stage-1 base and ASID of 0. `cfg_valid` and `evt_valid` are never high together.
- R13: A host write (`host_we`) stores `host_wdata` into the table that `host_sel` selects, at `host_addr`. The selections are: 0 for a stream entry, 1 for a level-1 descriptor, 2 for a context descriptor.
  - Stream entry layout: s2 base [31:0], VMID [47:32], cd_base [52:48], cd_log2 [55:53], stage-1 enable [56], valid [57].
  - Level-1 descriptor layout: pointer [5:0], valid [6].
  - Context descriptor layout: s1 base [31:0], ASID [47:32], valid [48].
  - Several entries may share one descriptor range and one stage-2 base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Table write strobe |
| host_sel | input | 2 | Table select: 0 stream entry, 1 level-1 descriptor, 2 context descriptor |
| host_addr | input | 6 | Write index |
| host_wdata | input | 58 | Write word |
| mode_two_level | input | 1 | 1 selects the two-level layout |
| l2_bits | input | 3 | Number of stream ID bits that index the level-2 array |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_sid | input | 6 | Stream ID |
| req_ssid_vld | input | 1 | Request carries a substream ID |
| req_ssid | input | 6 | Substream ID |
| cfg_valid | output | 1 | Configuration pulse |
| cfg_sid | output | 6 | Stream ID of the result |
| cfg_s1_en | output | 1 | Stage 1 in use |
| cfg_s1_base | output | 32 | Stage-1 table base |
| cfg_asid | output | 16 | ASID |
| cfg_s2_base | output | 32 | Stage-2 table base |
| cfg_vmid | output | 16 | VMID |
| evt_valid | output | 1 | Fault event pulse |
| evt_sid | output | 6 | Stream ID of the faulting request |
| evt_cause | output | 3 | Fault cause, 1 to 5 |

## Verification
Internal errors show up at the ports within the lookup they affect.

- A wrong latched index, whether a bad shift or mask in the two-level split or a bad descriptor offset, returns the fields of a neighbouring entry. It can also return the wrong cause code, in the result pulse of that same request.
- A mis-sequenced state machine shows up as the wrong count of edges between acceptance and the pulse, or as `req_ready` staying high while busy.
- A mode or split sampled at the wrong time shows up only when those inputs change mid-lookup, so the bench changes them there.

// File: rtl/dma_stream_cfg_lookup.sv
module dma_stream_cfg_lookup #(
  parameter int SID_W  = 6,
  parameter int SSID_W = 6,
  parameter int CD_AW  = 5,
  parameter int BASE_W = 32,
  parameter int ID_W   = 16,
  parameter int SP_W   = $clog2(SID_W + 1),
  parameter int CL_W   = $clog2(SSID_W + 1),
  parameter int HA_W   = (SID_W > CD_AW) ? SID_W : CD_AW,
  parameter int WORD_W = BASE_W + ID_W + CD_AW + CL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              mode_two_level,
  input  logic [SP_W-1:0]   l2_bits,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SID_W-1:0]  req_sid,
  input  logic              req_ssid_vld,
  input  logic [SSID_W-1:0] req_ssid,
  output logic              cfg_valid,
  output logic [SID_W-1:0]  cfg_sid,
  output logic              cfg_s1_en,
  output logic [BASE_W-1:0] cfg_s1_base,
  output logic [ID_W-1:0]   cfg_asid,
  output logic [BASE_W-1:0] cfg_s2_base,
  output logic [ID_W-1:0]   cfg_vmid,
  output logic              evt_valid,
  output logic [SID_W-1:0]  evt_sid,
  output logic [2:0]        evt_cause
);
  localparam int STE_N  = 1 << SID_W;
  localparam int CD_N   = 1 << CD_AW;
  localparam int CD_W   = BASE_W + ID_W + 1;
  localparam int L1_W   = SID_W + 1;
  localparam int F_VMID = BASE_W;
  localparam int F_CDB  = BASE_W + ID_W;
  localparam int F_CDL  = F_CDB + CD_AW;
  localparam int F_S1   = F_CDL + CL_W;
  localparam int F_V    = F_S1 + 1;

  localparam logic [2:0] C_STE = 3'd1, C_L1 = 3'd2, C_DROP = 3'd3, C_RANGE = 3'd4, C_CD = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_STE, S_CD} st_t;

  logic [WORD_W-1:0] ste_mem [STE_N];
  logic [L1_W-1:0]   l1_mem  [STE_N];
  logic [CD_W-1:0]   cd_mem  [CD_N];

  st_t               st;
  logic [SID_W-1:0]  r_sid, ste_idx;
  logic [SSID_W-1:0] r_ssid;
  logic              r_has;
  logic [SP_W-1:0]   r_split;
  logic [CD_AW-1:0]  cd_idx;

  logic [L1_W-1:0]   l1_word;
  logic [SID_W-1:0]  low_mask, l2_idx;
  logic [WORD_W-1:0] ste_word;
  logic [CD_W-1:0]   cd_word;
  logic [SSID_W-1:0] ssid_eff;
  logic [CL_W-1:0]   ste_cdl;
  logic [CD_AW-1:0]  ste_cdb;
  logic              range_ok;

  assign req_ready = (st == S_IDLE);
  assign l1_word   = l1_mem[r_sid >> r_split];
  assign low_mask  = ~({SID_W{1'b1}} << r_split);
  assign l2_idx    = l1_word[SID_W-1:0] + (r_sid & low_mask);
  assign ste_word  = ste_mem[ste_idx];
  assign cd_word   = cd_mem[cd_idx];
  assign ssid_eff  = r_has ? r_ssid : '0;
  assign ste_cdl   = ste_word[F_CDL +: CL_W];
  assign ste_cdb   = ste_word[F_CDB +: CD_AW];
  assign range_ok  = (ssid_eff >> ste_cdl) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STE_N; i++) begin
        ste_mem[i] <= '0;
        l1_mem[i]  <= '0;
      end
      for (int i = 0; i < CD_N; i++) cd_mem[i] <= '0;
    end else if (host_we) begin
      case (host_sel)
        2'd0:    ste_mem[host_addr[SID_W-1:0]] <= host_wdata;
        2'd1:    l1_mem[host_addr[SID_W-1:0]]  <= host_wdata[L1_W-1:0];
        2'd2:    cd_mem[host_addr[CD_AW-1:0]]  <= host_wdata[CD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      r_sid       <= '0;
      r_ssid      <= '0;
      r_has       <= 1'b0;
      r_split     <= '0;
      ste_idx     <= '0;
      cd_idx      <= '0;
      cfg_valid   <= 1'b0;
      cfg_sid     <= '0;
      cfg_s1_en   <= 1'b0;
      cfg_s1_base <= '0;
      cfg_asid    <= '0;
      cfg_s2_base <= '0;
      cfg_vmid    <= '0;
      evt_valid   <= 1'b0;
      evt_sid     <= '0;
      evt_cause   <= '0;
    end else begin
      cfg_valid <= 1'b0;
      evt_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          r_sid   <= req_sid;
          r_ssid  <= req_ssid;
          r_has   <= req_ssid_vld;
          r_split <= l2_bits;
          ste_idx <= req_sid;
          st      <= mode_two_level ? S_L1 : S_STE;
        end
        S_L1: begin
          if (!l1_word[SID_W]) begin
            evt_valid <= 1'b1;
            evt_sid   <= r_sid;
            evt_cause <= C_L1;
            st        <= S_IDLE;
          end else begin
            ste_idx <= l2_idx;
            st      <= S_STE;
          end
        end
        S_STE: begin
          cfg_s2_base <= ste_word[BASE_W-1:0];
          cfg_vmid    <= ste_word[F_VMID +: ID_W];
          cfg_sid     <= r_sid;
          cd_idx      <= ste_cdb + CD_AW'(ssid_eff);
          if (!ste_word[F_V] || (r_has && !ste_word[F_S1]) || (ste_word[F_S1] && !range_ok)) begin
            evt_valid <= 1'b1;
            evt_sid   <= r_sid;
            evt_cause <= !ste_word[F_V] ? C_STE : (!ste_word[F_S1] ? C_DROP : C_RANGE);
            st        <= S_IDLE;
          end else if (!ste_word[F_S1]) begin
            cfg_valid   <= 1'b1;
            cfg_s1_en   <= 1'b0;
            cfg_s1_base <= '0;
            cfg_asid    <= '0;
            st          <= S_IDLE;
          end else begin
            st <= S_CD;
          end
        end
        S_CD: begin
          if (!cd_word[CD_W-1]) begin
            evt_valid <= 1'b1;
            evt_sid   <= r_sid;
            evt_cause <= C_CD;
          end else begin
            cfg_valid   <= 1'b1;
            cfg_s1_en   <= 1'b1;
            cfg_s1_base <= cd_word[BASE_W-1:0];
            cfg_asid    <= cd_word[BASE_W +: ID_W];
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_stream_cfg_lookup_chk.sv
module dma_stream_cfg_lookup_chk #(
  parameter int BASE_W = 32,
  parameter int ID_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cfg_valid,
  input logic              cfg_s1_en,
  input logic [BASE_W-1:0] cfg_s1_base,
  input logic [ID_W-1:0]   cfg_asid,
  input logic              evt_valid,
  input logic [2:0]        evt_cause
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (req_ready && !cfg_valid && !evt_valid);
    end
  end

  assert_single_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && evt_valid));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_result_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid || evt_valid) |=> !(cfg_valid || evt_valid));

  assert_result_ends_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid || evt_valid) |-> (req_ready && !$past(req_ready)));

  assert_s1_fields_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_s1_en) |-> (cfg_s1_base == '0 && cfg_asid == '0));

  assert_cause_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_cause >= 3'd1 && evt_cause <= 3'd5));
endmodule

bind dma_stream_cfg_lookup dma_stream_cfg_lookup_chk #(.BASE_W(BASE_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cfg_valid(cfg_valid), .cfg_s1_en(cfg_s1_en), .cfg_s1_base(cfg_s1_base),
  .cfg_asid(cfg_asid), .evt_valid(evt_valid), .evt_cause(evt_cause)
);

// File: tb/tb_dma_stream_cfg_lookup.sv
`timescale 1ns/1ps
module tb_dma_stream_cfg_lookup;
  logic        clk = 0, rst_n = 0;
  logic        host_we = 0;
  logic [1:0]  host_sel = 0;
  logic [5:0]  host_addr = 0;
  logic [57:0] host_wdata = 0;
  logic        mode_two_level = 0;
  logic [2:0]  l2_bits = 0;
  logic        req_valid = 0, req_ssid_vld = 0;
  logic [5:0]  req_sid = 0, req_ssid = 0;
  logic        req_ready, cfg_valid, cfg_s1_en, evt_valid;
  logic [5:0]  cfg_sid, evt_sid;
  logic [31:0] cfg_s1_base, cfg_s2_base;
  logic [15:0] cfg_asid, cfg_vmid;
  logic [2:0]  evt_cause;

  int checks = 0, errors = 0;
  logic [57:0] m_ste [64];
  logic [6:0]  m_l1  [64];
  logic [48:0] m_cd  [32];

  always #4 clk = ~clk;

  dma_stream_cfg_lookup dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .mode_two_level(mode_two_level),
    .l2_bits(l2_bits), .req_valid(req_valid), .req_ready(req_ready), .req_sid(req_sid),
    .req_ssid_vld(req_ssid_vld), .req_ssid(req_ssid), .cfg_valid(cfg_valid),
    .cfg_sid(cfg_sid), .cfg_s1_en(cfg_s1_en), .cfg_s1_base(cfg_s1_base),
    .cfg_asid(cfg_asid), .cfg_s2_base(cfg_s2_base), .cfg_vmid(cfg_vmid),
    .evt_valid(evt_valid), .evt_sid(evt_sid), .evt_cause(evt_cause));

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [57:0] mk_ste(bit v, bit s1, int cdl, int cdb, int vmid, logic [31:0] s2);
    return {v, s1, 3'(cdl), 5'(cdb), 16'(vmid), s2};
  endfunction

  task automatic wr(input int sel, input int addr, input logic [57:0] d);
    @(negedge clk);
    host_we = 1; host_sel = 2'(sel); host_addr = 6'(addr); host_wdata = d;
    @(posedge clk);
    #1 host_we = 0;
    if (sel == 0) m_ste[addr] = d;
    else if (sel == 1) m_l1[addr] = d[6:0];
    else if (sel == 2) m_cd[addr & 31] = d[48:0];
  endtask

  task automatic model(input bit two, input int split, input int sid, input bit has, input int ssid,
                       output int cause, output int lat, output bit s1, output logic [31:0] s1b,
                       output logic [15:0] asid, output logic [31:0] s2b, output logic [15:0] vmid);
    int idx, se, cdl;
    logic [6:0] l1; logic [57:0] e; logic [48:0] c;
    cause = 0; lat = 0; s1 = 0; s1b = 0; asid = 0; s2b = 0; vmid = 0;
    if (two) begin
      lat = 1;
      l1 = m_l1[(sid >> split) & 63];
      if (!l1[6]) begin cause = 2; return; end
      idx = (int'(l1[5:0]) + (sid & ((1 << split) - 1))) & 63;
    end else idx = sid;
    lat++;
    e = m_ste[idx];
    if (!e[57]) begin cause = 1; return; end
    if (has && !e[56]) begin cause = 3; return; end
    s2b = e[31:0]; vmid = e[47:32];
    if (!e[56]) return;
    se = has ? ssid : 0;
    cdl = int'(e[55:53]);
    if ((se >> cdl) != 0) begin cause = 4; return; end
    lat++;
    c = m_cd[(int'(e[52:48]) + se) & 31];
    if (!c[48]) begin cause = 5; return; end
    s1 = 1; s1b = c[31:0]; asid = c[47:32];
  endtask

  task automatic run_req(input bit two, input int split, input int sid, input bit has,
                         input int ssid, input bit disturb);
    int ecause, elat, k; bit es1, got; string rq;
    logic [31:0] es1b, es2b; logic [15:0] easid, evmid;
    model(two, split, sid, has, ssid, ecause, elat, es1, es1b, easid, es2b, evmid);
    case (ecause)
      1: rq = "R7"; 2: rq = "R8"; 3: rq = "R9"; 4: rq = "R10"; 5: rq = "R11";
      default: rq = two ? "R5" : (es1 ? "R4" : "R3");
    endcase
    if (disturb) rq = {rq, "/R6"};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; mode_two_level = two; l2_bits = 3'(split);
    req_sid = 6'(sid); req_ssid_vld = has; req_ssid = 6'(ssid);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2", "ready while busy", req_ready, 0);
    if (disturb) begin mode_two_level = ~two; l2_bits = 3'((split + 3) % 7); end
    got = 0; k = 0;
    for (int n = 1; n <= 8; n++) begin
      if (n > 1) @(negedge clk);
      if (cfg_valid || evt_valid) begin k = n; got = 1; break; end
    end
    chk(got, rq, "result seen", got, 1);
    chk(k - 1 == elat, {rq, "/R2"}, "latency", k - 1, elat);
    if (ecause == 0) begin
      chk(cfg_valid && !evt_valid, rq, "cfg pulse", evt_valid, 0);
      chk(cfg_sid == 6'(sid), {rq, "/R12"}, "cfg sid", cfg_sid, sid);
      chk(cfg_s2_base == es2b && cfg_vmid == evmid, rq, "s2 base/vmid", {cfg_s2_base, cfg_vmid}, {es2b, evmid});
      chk(cfg_s1_en == es1 && cfg_s1_base == es1b && cfg_asid == easid, {rq, "/R12"}, "s1 fields",
          {cfg_s1_en, cfg_s1_base, cfg_asid}, {es1, es1b, easid});
    end else begin
      chk(evt_valid && !cfg_valid, rq, "event pulse", cfg_valid, 0);
      chk(evt_sid == 6'(sid), {rq, "/R12"}, "event sid", evt_sid, sid);
      chk(int'(evt_cause) == ecause, rq, "cause", evt_cause, ecause);
    end
    @(negedge clk);
    chk(!cfg_valid && !evt_valid, "R2", "single pulse", {cfg_valid, evt_valid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 64; i++) begin m_ste[i] = '0; m_l1[i] = '0; end
    for (int i = 0; i < 32; i++) m_cd[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !cfg_valid && !evt_valid, "R1", "in reset", {req_ready, cfg_valid, evt_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !cfg_valid && !evt_valid, "R1", "after reset", {req_ready, cfg_valid, evt_valid}, 3'b100);

    for (int i = 0; i < 64; i++)
      wr(0, i, mk_ste(($urandom % 8) != 0, $urandom % 2, $urandom % 8, $urandom % 32, $urandom, $urandom));
    for (int i = 0; i < 64; i++) wr(1, i, 58'({($urandom % 6) != 0, 6'($urandom)}));
    for (int i = 0; i < 32; i++) wr(2, i, 58'({($urandom % 6) != 0, 16'($urandom), 32'($urandom)}));

    // R3, R9: stage 1 off
    wr(0, 5, mk_ste(1, 0, 0, 0, 16'h00aa, 32'h1111_0000));
    run_req(0, 0, 5, 0, 0, 0);
    run_req(0, 0, 5, 1, 2, 0);
    // R4, R10, R13 sharing: two streams on one descriptor range and stage-2 base
    wr(0, 6, mk_ste(1, 1, 2, 30, 16'h0bb0, 32'h2222_0000));
    wr(0, 7, mk_ste(1, 1, 2, 30, 16'h0bb0, 32'h2222_0000));
    wr(2, 30, 58'({1'b1, 16'h0c30, 32'h3333_0030}));
    wr(2, 1, 58'({1'b1, 16'h0c01, 32'h3333_0001}));
    run_req(0, 0, 6, 1, 3, 0);
    run_req(0, 0, 7, 1, 3, 0);
    run_req(0, 0, 6, 0, 0, 0);
    run_req(0, 0, 6, 1, 4, 0);
    // R11, R7
    wr(0, 8, mk_ste(1, 1, 6, 20, 16'h0008, 32'h4444_0000));
    wr(2, 20, 58'(0));
    run_req(0, 0, 8, 0, 0, 0);
    wr(0, 9, mk_ste(0, 1, 6, 0, 0, 0));
    run_req(0, 0, 9, 0, 0, 0);
    // R5, R8, R6
    wr(1, 3, 58'({1'b1, 6'd40}));
    wr(0, 41, mk_ste(1, 0, 0, 0, 16'h0041, 32'h5555_0041));
    run_req(1, 2, 13, 0, 0, 0);
    run_req(1, 2, 13, 0, 0, 1);
    wr(1, 4, 58'(0));
    run_req(1, 2, 17, 0, 0, 0);
    wr(1, 0, 58'({1'b1, 6'd60}));
    run_req(1, 6, 9, 0, 0, 0);
    run_req(1, 0, 5, 0, 0, 1);
    run_req(0, 0, 6, 1, 1, 1);

    for (int i = 0; i < 400; i++)
      run_req($urandom % 2, $urandom % 7, $urandom % 64, $urandom % 2, $urandom % 64, ($urandom % 4) == 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule